// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side front end of a byte-wide flash command port. On every write strobe it samples an 8-bit bus together with a command/address select level. Low means a command byte and high means an address byte. It follows the multi-byte sequences, collects a 15-bit sector number and a 12-bit column number, and passes finished read, program and erase operations to a back end as single requests. The array, the status register and the interface timing sit outside the block.

Requests leave on a valid/ready channel. A request stays on the channel unchanged until the back end takes it, and while it waits the decoder ignores every write strobe, so back-pressure stalls the command port instead of losing an operation. A serial column pointer steps on each serial-clock pulse during data transfer and reports whether the current column still lies inside the page. The back end drives a plain busy level, and while it is high every command byte is refused, the reset code included.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in standby with status read selected (`status_mode`=1), and `req_valid`, `id_mode`, `col_err` and `xfer_ok` are all 0.
- R2: The sector number is collected from two address bytes. The first byte gives bits 7..0. Bits 6..0 of the second byte give bits 14..8, and bit 7 of the second byte is discarded.
- R3: Command 00H or F0H, followed by the two sector bytes, raises a read request after the second sector byte. For 00H the start column is 0 and for F0H it is 800H. The `req_op` codes are: 0 full read, 1 spare read, 2 recovery read, 3 erase, 4 additive program (10H), 5 rewrite program (11H), 6 full program (1FH), 7 spare program (0FH), 8 recovery write (12H).
- R4: Command 90H enters identifier mode. In that mode `id_code` shows 07H while `cde` is low and 9DH while `cde` is high.
- R5: Command 01H raises a recovery read request at once, with sector 0 and column 0.
- R6: Command 20H and two sector bytes raise nothing. The erase request is raised only when confirm byte B0H follows.
- R7: Commands 10H, 11H, 1FH, 0FH and 12H each take two sector bytes and raise their program request only when confirm byte 40H follows. The request column is 0, or 800H for 0FH, or the last valid column pair.
- R8: With 00H, 10H or 11H, address-byte pairs after the sector bytes give a column (low byte, then bits 11..8 from bits 3..0 of the second byte). Each valid pair reloads the serial pointer, and pairs may repeat. For the other opcodes, address bytes at that point are ignored.
- R9: Each serial-clock pulse in transfer advances `xfer_col` by one. `xfer_ok` is 1 only while `xfer_col` is below 840H. The pointer stops at 840H, so a full read gives 2112 valid bytes and a spare read gives 64.
- R10: While `busy` is 1, no write strobe has any effect, FFH and 50H included.
- R11: When not busy and not waiting on a request, FFH returns the decoder to standby, and 50H gives a one-cycle `clr_stat` pulse and returns it to standby.
- R12: An unrecognised byte in a command slot is ignored, and the decoder stays where it was.
- R13: A column pair of 840H or more sets `col_err`, which forces `xfer_ok` to 0 and makes a program confirm be ignored. The next valid pair clears it.
- R14: While `req_valid` is 1 and `req_ready` is 0, the request fields hold steady and all write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One-cycle write strobe that samples `bus_in` and `cde` |
| bus_in | input | 8 | Command or address byte |
| cde | input | 1 | 0: command byte, 1: address byte; also selects the identifier byte |
| sc_stb | input | 1 | One-cycle serial clock pulse |
| busy | input | 1 | Back end is running an operation |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Back end takes the request |
| req_op | output | 4 | Request code (see R3) |
| req_sector | output | 15 | Request sector |
| req_col | output | 12 | Request start column |
| xfer_col | output | 12 | Serial column pointer |
| xfer_ok | output | 1 | Pointer is in a live transfer and inside the page |
| col_err | output | 1 | Last column pair was out of range |
| status_mode | output | 1 | Standby with status read selected |
| id_mode | output | 1 | Identifier mode |
| id_code | output | 8 | Identifier byte |
| clr_stat | output | 1 | Status clear pulse |

## Verification
The hardest states to reach are a request stalled on the channel while more command bytes arrive, and a program setup holding an out-of-range column when the confirm byte lands. The stimulus holds `req_ready` low across a full read sequence and then sends an identifier command into the stall. It also feeds a column pair of 845H ahead of a 40H confirm, then a legal pair and a second confirm, so that both the refused and the accepted confirm are checked at the request channel.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_RD_FULL  = 8'h00;
  localparam logic [7:0] CMD_RD_SPARE = 8'hF0;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_RD_RECOV = 8'h01;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO = 8'hB0;
  localparam logic [7:0] CMD_PG_ADD   = 8'h10;
  localparam logic [7:0] CMD_PG_REWR  = 8'h11;
  localparam logic [7:0] CMD_PG_FULL  = 8'h1F;
  localparam logic [7:0] CMD_PG_SPARE = 8'h0F;
  localparam logic [7:0] CMD_RECOV_WR = 8'h12;
  localparam logic [7:0] CMD_PROG_GO  = 8'h40;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;

  typedef enum logic [3:0] {
    OP_RD_FULL, OP_RD_SPARE, OP_RD_RECOV, OP_ERASE, OP_PG_ADD,
    OP_PG_REWR, OP_PG_FULL, OP_PG_SPARE, OP_RECOV_WR
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SA_LO, ST_SA_HI, ST_XFER, ST_IDENT, ST_RECOV
  } st_e;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W     = 15,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112,
  parameter int SPARE_BASE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        bus_in,
  input  logic              cde,
  input  logic              busy,
  input  logic              req_ready,
  output logic              req_valid,
  output op_e               req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic [COL_W-1:0]  req_col,
  output logic              ld_col,
  output logic [COL_W-1:0]  ld_val,
  output logic              xfer_en,
  output logic              col_err,
  output logic              status_mode,
  output logic              id_mode,
  output logic              clr_stat
);
  localparam int SA_HI_W = SECT_W - 8;
  localparam int CA_HI_W = COL_W - 8;
  localparam logic [COL_W-1:0] COL_END   = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] COL_SPARE = COL_W'(SPARE_BASE);

  st_e               st_q;
  op_e               op_q;
  logic [SECT_W-1:0] sector_q;
  logic [COL_W-1:0]  col_base_q;
  logic [7:0]        ca_lo_q;
  logic              ca_pend_q;

  function automatic logic is_read(op_e o);
    return (o == OP_RD_FULL) || (o == OP_RD_SPARE);
  endfunction
  function automatic logic takes_col(op_e o);
    return (o == OP_RD_FULL) || (o == OP_PG_ADD) || (o == OP_PG_REWR);
  endfunction
  function automatic logic is_prog(op_e o);
    return (o == OP_PG_ADD) || (o == OP_PG_REWR) || (o == OP_PG_FULL) ||
           (o == OP_PG_SPARE) || (o == OP_RECOV_WR);
  endfunction
  function automatic logic has_data(op_e o);
    return (o != OP_ERASE) && (o != OP_RECOV_WR);
  endfunction

  logic              accept, cmd_slot;
  logic [SECT_W-1:0] sect_full;
  logic [COL_W-1:0]  ca_full, start_col;

  assign accept    = wr_stb && !busy && !req_valid;
  assign cmd_slot  = (st_q == ST_IDLE) || (st_q == ST_IDENT) || (st_q == ST_RECOV) ||
                     ((st_q == ST_XFER) && is_read(op_q));
  assign sect_full = {bus_in[SA_HI_W-1:0], sector_q[7:0]};
  assign ca_full   = {bus_in[CA_HI_W-1:0], ca_lo_q};
  assign start_col = ((op_q == OP_RD_SPARE) || (op_q == OP_PG_SPARE)) ? COL_SPARE : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_RD_FULL;
      sector_q   <= '0;
      col_base_q <= '0;
      ca_lo_q    <= '0;
      ca_pend_q  <= 1'b0;
      col_err    <= 1'b0;
      req_valid  <= 1'b0;
      req_op     <= OP_RD_FULL;
      req_sector <= '0;
      req_col    <= '0;
      ld_col     <= 1'b0;
      ld_val     <= '0;
      clr_stat   <= 1'b0;
    end else begin
      clr_stat <= 1'b0;
      ld_col   <= 1'b0;
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (accept) begin
        if (!cde && bus_in == CMD_RESET) begin
          st_q      <= ST_IDLE;
          col_err   <= 1'b0;
          ca_pend_q <= 1'b0;
        end else if (!cde && cmd_slot) begin
          case (bus_in)
            CMD_RD_FULL:  begin op_q <= OP_RD_FULL;  st_q <= ST_SA_LO; end
            CMD_RD_SPARE: begin op_q <= OP_RD_SPARE; st_q <= ST_SA_LO; end
            CMD_ERASE:    begin op_q <= OP_ERASE;    st_q <= ST_SA_LO; end
            CMD_PG_ADD:   begin op_q <= OP_PG_ADD;   st_q <= ST_SA_LO; end
            CMD_PG_REWR:  begin op_q <= OP_PG_REWR;  st_q <= ST_SA_LO; end
            CMD_PG_FULL:  begin op_q <= OP_PG_FULL;  st_q <= ST_SA_LO; end
            CMD_PG_SPARE: begin op_q <= OP_PG_SPARE; st_q <= ST_SA_LO; end
            CMD_RECOV_WR: begin op_q <= OP_RECOV_WR; st_q <= ST_SA_LO; end
            CMD_IDENT:    st_q <= ST_IDENT;
            CMD_CLEAR:    begin clr_stat <= 1'b1; st_q <= ST_IDLE; end
            CMD_RD_RECOV: begin
              st_q       <= ST_RECOV;
              col_err    <= 1'b0;
              ca_pend_q  <= 1'b0;
              req_valid  <= 1'b1;
              req_op     <= OP_RD_RECOV;
              req_sector <= '0;
              req_col    <= '0;
              ld_col     <= 1'b1;
              ld_val     <= '0;
            end
            default: ;
          endcase
        end else if (cde) begin
          case (st_q)
            ST_SA_LO: begin
              sector_q[7:0] <= bus_in;
              st_q          <= ST_SA_HI;
            end
            ST_SA_HI: begin
              sector_q   <= sect_full;
              st_q       <= ST_XFER;
              col_base_q <= start_col;
              col_err    <= 1'b0;
              ca_pend_q  <= 1'b0;
              ld_col     <= 1'b1;
              ld_val     <= start_col;
              if (is_read(op_q)) begin
                req_valid  <= 1'b1;
                req_op     <= op_q;
                req_sector <= sect_full;
                req_col    <= start_col;
              end
            end
            ST_XFER: begin
              if (takes_col(op_q)) begin
                if (!ca_pend_q) begin
                  ca_lo_q   <= bus_in;
                  ca_pend_q <= 1'b1;
                end else begin
                  ca_pend_q <= 1'b0;
                  if (ca_full >= COL_END) begin
                    col_err <= 1'b1;
                  end else begin
                    col_err    <= 1'b0;
                    col_base_q <= ca_full;
                    ld_col     <= 1'b1;
                    ld_val     <= ca_full;
                  end
                end
              end
            end
            default: ;
          endcase
        end else if (st_q == ST_XFER) begin
          if ((op_q == OP_ERASE && bus_in == CMD_ERASE_GO) ||
              (is_prog(op_q) && bus_in == CMD_PROG_GO && !col_err && !ca_pend_q)) begin
            req_valid  <= 1'b1;
            req_op     <= op_q;
            req_sector <= sector_q;
            req_col    <= (op_q == OP_ERASE) ? '0 : col_base_q;
            st_q       <= ST_IDLE;
          end
        end
      end
    end
  end

  assign xfer_en     = !col_err && (((st_q == ST_XFER) && has_data(op_q)) || (st_q == ST_RECOV));
  assign status_mode = (st_q == ST_IDLE);
  assign id_mode     = (st_q == ST_IDENT);
endmodule

// File: rtl/flash_col_tracker.sv
module flash_col_tracker #(
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_col,
  input  logic [COL_W-1:0] ld_val,
  input  logic             step,
  output logic [COL_W-1:0] ptr,
  output logic             in_range
);
  localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ptr <= '0;
    else if (ld_col)                   ptr <= ld_val;
    else if (step && ptr < COL_END)    ptr <= ptr + 1'b1;
  end

  assign in_range = (ptr < COL_END);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         SECT_W     = 15,
  parameter int         COL_W      = 12,
  parameter int         PAGE_BYTES = 2112,
  parameter int         SPARE_BASE = 2048,
  parameter logic [7:0] MFR_CODE   = 8'h07,
  parameter logic [7:0] DEV_CODE   = 8'h9D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        bus_in,
  input  logic              cde,
  input  logic              sc_stb,
  input  logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic [COL_W-1:0]  req_col,
  output logic [COL_W-1:0]  xfer_col,
  output logic              xfer_ok,
  output logic              col_err,
  output logic              status_mode,
  output logic              id_mode,
  output logic [7:0]        id_code,
  output logic              clr_stat
);
  op_e              op_w;
  logic             ld_col, xfer_en, in_range;
  logic [COL_W-1:0] ld_val;

  flash_cmd_seq #(
    .SECT_W(SECT_W), .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES), .SPARE_BASE(SPARE_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .bus_in(bus_in), .cde(cde),
    .busy(busy), .req_ready(req_ready), .req_valid(req_valid), .req_op(op_w),
    .req_sector(req_sector), .req_col(req_col), .ld_col(ld_col), .ld_val(ld_val),
    .xfer_en(xfer_en), .col_err(col_err), .status_mode(status_mode),
    .id_mode(id_mode), .clr_stat(clr_stat)
  );

  flash_col_tracker #(.COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES)) u_col (
    .clk(clk), .rst_n(rst_n), .ld_col(ld_col), .ld_val(ld_val),
    .step(sc_stb && xfer_en), .ptr(xfer_col), .in_range(in_range)
  );

  assign req_op  = op_w;
  assign xfer_ok = xfer_en && in_range;
  assign id_code = id_mode ? (cde ? DEV_CODE : MFR_CODE) : 8'h00;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int SECT_W     = 15,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              sc_stb,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic [SECT_W-1:0] req_sector,
  input logic [COL_W-1:0]  req_col,
  input logic [COL_W-1:0]  xfer_col,
  input logic              xfer_ok,
  input logic              col_err,
  input logic              status_mode,
  input logic              id_mode,
  input logic              clr_stat
);
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_stb |=> !$rose(req_valid) && !clr_stat && $stable(status_mode) && $stable(id_mode)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_sector) && $stable(req_col)); // R14
  AST_XFER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> xfer_col < COL_W'(PAGE_BYTES)); // R9
  AST_ERR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    col_err |-> !xfer_ok); // R13
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok && sc_stb && !wr_stb && !$past(wr_stb) |=> xfer_col == $past(xfer_col) + 1'b1); // R9
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (.*);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_stb = 1'b0, cde = 1'b0, sc_stb = 1'b0, busy = 1'b0, req_ready = 1'b1;
  logic [7:0]  bus_in = 8'h00;
  logic        req_valid, xfer_ok, col_err, status_mode, id_mode, clr_stat;
  logic [3:0]  req_op;
  logic [14:0] req_sector;
  logic [11:0] req_col, xfer_col;
  logic [7:0]  id_code;

  int n_chk = 0, n_fail = 0, n_clr = 0;
  logic [30:0] exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .bus_in(bus_in), .cde(cde),
    .sc_stb(sc_stb), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sector(req_sector), .req_col(req_col), .xfer_col(xfer_col),
    .xfer_ok(xfer_ok), .col_err(col_err), .status_mode(status_mode),
    .id_mode(id_mode), .id_code(id_code), .clr_stat(clr_stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(input logic [3:0] op, input logic [14:0] s, input logic [11:0] c);
    return {op, s, c};
  endfunction

  task automatic wr(input logic [7:0] b, input logic c);
    @(negedge clk); wr_stb = 1'b1; bus_in = b; cde = c;
    @(negedge clk); wr_stb = 1'b0; cde = 1'b0;
    @(negedge clk);
  endtask

  task automatic sc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sc_stb = 1'b1;
      @(negedge clk); sc_stb = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on every accepted request
  always @(negedge clk) begin
    #2;
    if (rst_n && clr_stat) n_clr++;
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) chk("R6/R7 unexpected request", {1'b0, req_op, req_sector, req_col}, 32'h0);
      else chk("R3/R5/R6/R7 request fields", {1'b0, req_op, req_sector, req_col}, {1'b0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status_mode", status_mode, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 id_mode/col_err/xfer_ok", {id_mode, col_err, xfer_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 full read, bit 7 of the high sector byte discarded
    wr(8'h00, 0); wr(8'h34, 1);
    exp_q.push_back(mk(4'd0, 15'h5234, 12'h000));
    wr(8'hD2, 1);
    chk("R2 R3 read start col", xfer_col, 12'h000);
    chk("R3 status left standby", status_mode, 0);
    sc(5);
    chk("R9 pointer step", xfer_col, 12'h005);
    // R8 column pair reload near the page end
    wr(8'h3E, 1); wr(8'h08, 1);
    chk("R8 reload", xfer_col, 12'h83E);
    sc(1);
    chk("R9 last-but-one ok", {xfer_ok, xfer_col}, {1'b1, 12'h83F});
    sc(1);
    chk("R9 end reached", {xfer_ok, xfer_col}, {1'b0, 12'h840});
    sc(3);
    chk("R9 saturate", xfer_col, 12'h840);
    wr(8'h00, 1); wr(8'h01, 1);
    chk("R8 repeat pair", {xfer_ok, xfer_col}, {1'b1, 12'h100});

    // R3 spare read: 64 valid bytes from 800H
    exp_q.push_back(mk(4'd1, 15'h0001, 12'h800));
    wr(8'hF0, 0); wr(8'h01, 1); wr(8'h00, 1);
    chk("R3 spare start", {xfer_ok, xfer_col}, {1'b1, 12'h800});
    sc(63);
    chk("R9 spare 64th", {xfer_ok, xfer_col}, {1'b1, 12'h83F});
    sc(1);
    chk("R9 spare past end", xfer_ok, 0);
    wr(8'h00, 1); wr(8'h00, 1);
    chk("R8 pair ignored for spare", xfer_col, 12'h840);

    // R4 identifier
    wr(8'h90, 0);
    chk("R4 id_mode", id_mode, 1);
    #1 chk("R4 maker code", id_code, 8'h07);
    @(negedge clk); cde = 1'b1; #1;
    chk("R4 device code", id_code, 8'h9D);
    cde = 1'b0;
    wr(8'hFF, 0);
    chk("R11 reset to standby", status_mode, 1);

    // R12 unknown opcode
    wr(8'h77, 0);
    chk("R12 unknown ignored", {status_mode, id_mode}, 2'b10);

    // R5 recovery read
    exp_q.push_back(mk(4'd2, 15'h0000, 12'h000));
    wr(8'h01, 0);
    chk("R5 pointer at 0", {xfer_ok, xfer_col}, {1'b1, 12'h000});
    wr(8'hFF, 0);

    // R6 erase only on confirm
    wr(8'h20, 0); wr(8'h10, 1); wr(8'h20, 1);
    chk("R6 no request before confirm", {req_valid, status_mode}, 2'b00);
    exp_q.push_back(mk(4'd3, 15'h2010, 12'h000));
    wr(8'hB0, 0);
    chk("R6 back to standby", status_mode, 1);

    // R10 busy lockout
    busy = 1'b1;
    wr(8'h50, 0); wr(8'h00, 0);
    chk("R10 busy ignores clear", n_clr, 0);
    chk("R10 busy ignores command", status_mode, 1);
    busy = 1'b0;
    wr(8'h0F, 0); wr(8'h05, 1); wr(8'h00, 1);
    busy = 1'b1;
    wr(8'hFF, 0); wr(8'h40, 0);
    chk("R10 FFH refused while busy", status_mode, 0);
    busy = 1'b0;
    exp_q.push_back(mk(4'd7, 15'h0005, 12'h800));
    wr(8'h40, 0);
    chk("R7 spare program issued", status_mode, 1);

    // R11 clear status pulse
    wr(8'h50, 0);
    chk("R11 clear pulse", n_clr, 1);

    // R13 column error blocks confirm
    wr(8'h10, 0); wr(8'h00, 1); wr(8'h01, 1);
    wr(8'h45, 1); wr(8'h08, 1);
    chk("R13 col_err set", {col_err, xfer_ok}, 2'b10);
    wr(8'h40, 0);
    chk("R13 confirm refused", status_mode, 0);
    wr(8'h10, 1); wr(8'h00, 1);
    chk("R13 error cleared", {col_err, xfer_col}, {1'b0, 12'h010});
    exp_q.push_back(mk(4'd4, 15'h0100, 12'h010));
    wr(8'h40, 0);

    // R7 remaining program forms
    wr(8'h11, 0); wr(8'h02, 1); wr(8'h00, 1); sc(3);
    chk("R7 rewrite data step", xfer_col, 12'h003);
    exp_q.push_back(mk(4'd5, 15'h0002, 12'h000));
    wr(8'h40, 0);
    wr(8'h1F, 0); wr(8'h03, 1); wr(8'h00, 1);
    exp_q.push_back(mk(4'd6, 15'h0003, 12'h000));
    wr(8'h40, 0);
    wr(8'h12, 0); wr(8'h04, 1); wr(8'h00, 1);
    exp_q.push_back(mk(4'd8, 15'h0004, 12'h000));
    wr(8'h40, 0);

    // R14 back-pressure
    req_ready = 1'b0;
    wr(8'h00, 0); wr(8'h09, 1); wr(8'h00, 1);
    repeat (3) @(negedge clk);
    chk("R14 held", {req_valid, req_op, req_sector}, {1'b1, 4'd0, 15'h0009});
    wr(8'h90, 0);
    chk("R14 write ignored while stalled", id_mode, 0);
    exp_q.push_back(mk(4'd0, 15'h0009, 12'h000));
    @(negedge clk); req_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R14 drained", req_valid, 0);
    wr(8'hFF, 0);

    repeat (3) @(negedge clk);
    chk("R7 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule